// File: doc/BRIEF.md
# Connection Memory Block Programmer

This block lets a microprocessor load one value into every low word of a switch's connection memory with a single register write, without writing each word itself. It holds a 16-bit mode register. That register carries a start bit, a 3-bit fill value and two pad-control bits, and the pad-control bits are passed out to the pad logic. The block also receives an enable bit that lives in a separate control register elsewhere in the chip.

When software raises the start bit while the enable is high, the block waits for the next frame pulse from the switching timebase. It then takes over the connection memory write port and writes the fill value into every address in turn, one word per clock. It then waits for the following frame pulse and clears the start bit to report that it has finished, so the whole operation spans two frame boundaries. Either clearing the start bit or dropping the enable aborts the fill part-way through. While the block is busy, normal microprocessor writes to the connection memory are discarded.

The frame period is assumed to be longer than the sweep. A frame pulse that arrives during the sweep is not counted.

Top module: `cm_block_fill`

## Requirements
- R1: After reset the mode register reads 0x0000 at register address `MODE_ADDR`, `busy` is 0, and a read of any other register address returns 0.
- R2: Only mode register bits 0, 3:1, 6 and 8 can be written (write mask 0x014F), and every other bit reads 0. `pad_bidir` follows bit 6 and `pad_pulldown_en` follows bit 8.
- R3: A fill starts only when a write sets bit 0 while bit 0 was 0 and `blk_prog_en` is 1. A write of 1 made while the enable is low stores the bit but starts nothing, and a later write of 1 over a stored 1 also starts nothing.
- R4: `busy` rises in the cycle after the start write. The sweep begins in the cycle after the first frame pulse sampled after the start write, and it writes addresses 0 to `CM_DEPTH-1` in ascending order, one per clock.
- R5: Every sweep write carries bits 15:3 = 0 and bits 2:0 = the fill value, which is mode register bits 3:1 as written together with the start bit.
- R6: After the last address, the next frame pulse completes the fill. In the following cycle `busy` is 0 and bit 0 reads 0, with bits 15:1 unchanged.
- R7: A mode register write with bit 0 = 0 while busy aborts the fill. From the next cycle on, no sweep writes occur, `busy` is 0, bit 0 reads 0 and the other bits are unchanged.
- R8: `blk_prog_en` sampled low while busy aborts the fill in the same way as R7.
- R9: While busy, a mode register write with bit 0 = 1 changes no bit.
- R10: While busy and not sweeping, microprocessor connection memory writes are discarded (`cm_we` = 0). While idle they pass through to the memory port in the same cycle with their address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame boundary strobe from the timebase |
| blk_prog_en | input | 1 | Block-programming enable from the control register |
| up_wr | input | 1 | Microprocessor register write strobe |
| up_addr | input | REG_AW | Register address |
| up_wdata | input | 16 | Register write data |
| up_rdata | output | 16 | Register read data (combinational on `up_addr`) |
| uc_cm_we | input | 1 | Microprocessor connection memory write request |
| uc_cm_addr | input | CM_AW | Microprocessor connection memory address |
| uc_cm_wdata | input | 16 | Microprocessor connection memory data |
| cm_we | output | 1 | Connection memory low write enable |
| cm_addr | output | CM_AW | Connection memory write address |
| cm_wdata | output | 16 | Connection memory write data |
| busy | output | 1 | Fill in progress |
| pad_bidir | output | 1 | Bidirectional pad mode select (bit 6) |
| pad_pulldown_en | output | 1 | Pad pull-down enable (bit 8) |

## Verification
The bench runs complete fills with different fill values. This tells a correct latch of bits 3:1 apart from stale or shifted data, and it shows that the sweep is aligned to two separate frame pulses and not to the start write. It starts a fill with the enable low, and rewrites a 1 over a stored 1, to separate a real rising edge from a level. It aborts the fill once by a register write and once by the enable, each part-way through a sweep, to show that sweep writes stop at once. It also sends register writes and connection memory writes while the block is busy, to show that they are held off, while the same writes made when idle pass through. A behavioural model is compared with the memory port, `busy` and the read data on every clock.

// File: rtl/cm_block_fill.sv
module cm_block_fill #(
  parameter int CM_DEPTH  = 1024,
  parameter int REG_AW    = 8,
  parameter int MODE_ADDR = 1,
  localparam int CM_AW    = (CM_DEPTH > 1) ? $clog2(CM_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_pulse,
  input  logic              blk_prog_en,
  input  logic              up_wr,
  input  logic [REG_AW-1:0] up_addr,
  input  logic [15:0]       up_wdata,
  output logic [15:0]       up_rdata,
  input  logic              uc_cm_we,
  input  logic [CM_AW-1:0]  uc_cm_addr,
  input  logic [15:0]       uc_cm_wdata,
  output logic              cm_we,
  output logic [CM_AW-1:0]  cm_addr,
  output logic [15:0]       cm_wdata,
  output logic              busy,
  output logic              pad_bidir,
  output logic              pad_pulldown_en
);
  localparam logic [15:0] RW_MASK = 16'h014F;
  localparam logic [REG_AW-1:0] MODE_A = REG_AW'(MODE_ADDR);
  localparam logic [CM_AW-1:0] LAST_A = CM_AW'(CM_DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_SWEEP, S_TAIL} st_t;

  st_t              state;
  logic [15:0]      mode_q;
  logic [CM_AW-1:0] sweep_addr;

  wire mode_sel   = up_wr && (up_addr == MODE_A);
  wire start_edge = mode_sel && up_wdata[0] && !mode_q[0] && blk_prog_en;
  wire sweeping   = (state == S_SWEEP);
  wire abort      = busy && (!blk_prog_en || (mode_sel && !up_wdata[0]));

  assign busy            = (state != S_IDLE);
  assign up_rdata        = (up_addr == MODE_A) ? mode_q : 16'h0000;
  assign pad_bidir       = mode_q[6];
  assign pad_pulldown_en = mode_q[8];
  assign cm_we           = sweeping || (uc_cm_we && !busy);
  assign cm_addr         = sweeping ? sweep_addr : uc_cm_addr;
  assign cm_wdata        = sweeping ? {13'h0000, mode_q[3:1]} : uc_cm_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      mode_q     <= 16'h0000;
      sweep_addr <= '0;
    end else if (!busy) begin
      if (mode_sel) mode_q <= up_wdata & RW_MASK;
      if (start_edge) state <= S_ARM;
    end else if (abort) begin
      state     <= S_IDLE;
      mode_q[0] <= 1'b0;
    end else begin
      case (state)
        S_ARM: if (frame_pulse) begin
          state      <= S_SWEEP;
          sweep_addr <= '0;
        end
        S_SWEEP: begin
          sweep_addr <= sweep_addr + 1'b1;
          if (sweep_addr == LAST_A) state <= S_TAIL;
        end
        S_TAIL: if (frame_pulse) begin
          state     <= S_IDLE;
          mode_q[0] <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~RW_MASK) == 16'h0000);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && $past(sweeping)) |-> (cm_addr == $past(cm_addr) + 1'b1));

  assert_fill_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cm_we) |-> (cm_wdata[15:3] == 13'h0000));

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mode_q[0]);

  assert_en_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blk_prog_en) |=> !busy);

  assert_hold_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && up_wr) |=> (mode_q[15:1] == $past(mode_q[15:1])));

  assert_uc_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sweeping) |-> !cm_we);
endmodule

// File: tb/cm_block_fill_tb.sv
module cm_block_fill_tb;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int FRAME = 40;

  logic        clk = 0, rst_n = 0, frame_pulse = 0, blk_prog_en = 0;
  logic        up_wr = 0;
  logic [7:0]  up_addr = 8'd1;
  logic [15:0] up_wdata = 0;
  logic [15:0] up_rdata;
  logic        uc_cm_we = 0;
  logic [AW-1:0] uc_cm_addr = 0;
  logic [15:0] uc_cm_wdata = 0;
  logic        cm_we, busy, pad_bidir, pad_pulldown_en;
  logic [AW-1:0] cm_addr;
  logic [15:0] cm_wdata;

  int tests = 0, fails = 0;

  cm_block_fill #(.CM_DEPTH(DEPTH), .REG_AW(8), .MODE_ADDR(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .blk_prog_en(blk_prog_en),
    .up_wr(up_wr), .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .uc_cm_we(uc_cm_we), .uc_cm_addr(uc_cm_addr), .uc_cm_wdata(uc_cm_wdata),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata), .busy(busy),
    .pad_bidir(pad_bidir), .pad_pulldown_en(pad_pulldown_en));

  always #5 clk = ~clk;

  // behavioural reference: m_ph 0 idle, 1 awaiting frame, 2 filling, 3 awaiting end frame
  int m_reg = 0, m_ph = 0, m_idx = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg = 0; m_ph = 0; m_idx = 0;
    end else begin
      bit sel;
      sel = up_wr && (up_addr == 8'd1);
      if (m_ph == 0) begin
        if (sel) begin
          if (up_wdata[0] && !m_reg[0] && blk_prog_en) m_ph = 1;
          m_reg = up_wdata & 16'h014F;
        end
      end else if (!blk_prog_en || (sel && !up_wdata[0])) begin
        m_ph = 0; m_reg = m_reg & ~1;
      end else if (m_ph == 1) begin
        if (frame_pulse) begin m_ph = 2; m_idx = 0; end
      end else if (m_ph == 2) begin
        if (m_idx == DEPTH - 1) m_ph = 3;
        m_idx = (m_idx + 1) % DEPTH;
      end else if (frame_pulse) begin
        m_ph = 0; m_reg = m_reg & ~1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit ewe;
      ewe = (m_ph == 2) || (uc_cm_we && m_ph == 0);
      chk("R10 cm_we", cm_we, ewe);
      if (ewe && cm_we) begin
        chk("R4 cm_addr", cm_addr, (m_ph == 2) ? m_idx : uc_cm_addr);
        chk("R5 cm_wdata", cm_wdata, (m_ph == 2) ? ((m_reg >> 1) & 7) : uc_cm_wdata);
      end
      chk("R6 busy", busy, m_ph != 0);
      chk("R9 up_rdata", up_rdata, (up_addr == 8'd1) ? m_reg : 0);
    end
  end

  int fcnt = 0;
  always @(negedge clk) begin
    frame_pulse <= (fcnt == FRAME - 1);
    fcnt = (fcnt + 1) % FRAME;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [15:0] d, input logic [7:0] a = 8'd1);
    @(negedge clk);
    up_wr = 1; up_addr = a; up_wdata = d;
    @(negedge clk);
    up_wr = 0; up_addr = 8'd1;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_sweep_at(input int a);
    for (int i = 0; i < 400 && !(busy && cm_we && cm_addr == AW'(a)); i++) @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    #1 rst_n = 1;
    cyc(1); #2;
    chk("R1 reset mode", up_rdata, 0);
    chk("R1 reset busy", busy, 0);
    up_addr = 8'd2; #1;
    chk("R1 other addr", up_rdata, 0);
    up_addr = 8'd1;

    // R3: enable low, start bit stored, no fill; reserved masked (R2)
    wr_mode(16'hFFFF);
    cyc(FRAME * 2); #2;
    chk("R3 no start en low", busy, 0);
    chk("R2 mask", up_rdata, 16'h014F);
    chk("R2 pad_bidir", pad_bidir, 1);
    chk("R2 pulldown", pad_pulldown_en, 1);
    blk_prog_en = 1;
    wr_mode(16'h0001);
    cyc(FRAME * 2); #2;
    chk("R3 one over one", busy, 0);
    wr_mode(16'h0000);
    wr_mode(16'h0040, 8'd3);
    #2 chk("R2 other addr write ignored", up_rdata, 0);

    // R10: pass-through when idle
    @(negedge clk);
    uc_cm_we = 1; uc_cm_addr = 4'd9; uc_cm_wdata = 16'hBEEF;
    #2 chk("R10 idle pass we", cm_we, 1);
    chk("R10 idle pass data", cm_wdata, 16'hBEEF);
    @(negedge clk) uc_cm_we = 0;

    // full fill value 5, with held-off writes while busy (R9, R10)
    wr_mode(16'h000B);
    #2 chk("R4 busy after start", busy, 1);
    @(negedge clk);
    uc_cm_we = 1; uc_cm_addr = 4'd3; uc_cm_wdata = 16'h1234;
    wr_mode(16'h0141);
    #2 chk("R9 write ignored", up_rdata, 16'h000B);
    uc_cm_we = 0;
    wait_idle; #2;
    chk("R6 done clears start", up_rdata, 16'h000A);

    // full fill value 2 with pads set
    wr_mode(16'h0145);
    wait_idle; #2;
    chk("R6 done value 2", up_rdata, 16'h0144);

    // R7: abort by register write
    wr_mode(16'h0007);
    wait_sweep_at(5);
    cyc(2);
    wr_mode(16'h0000);
    #2 chk("R7 abort busy", busy, 0);
    chk("R7 abort reg", up_rdata, 16'h0006);
    cyc(30);

    // R8: abort by enable drop
    wr_mode(16'h000D);
    wait_sweep_at(7);
    @(negedge clk) blk_prog_en = 0;
    @(negedge clk) blk_prog_en = 1;
    #2 chk("R8 abort busy", busy, 0);
    chk("R8 abort reg", up_rdata, 16'h000C);
    cyc(FRAME * 2); #2;
    chk("R8 stays idle", busy, 0);

    // full fill value 7 after aborts
    wr_mode(16'h000F);
    wait_idle; #2;
    chk("R6 done value 7", up_rdata, 16'h000E);
    cyc(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule